// File: doc/BRIEF.md
# DAC Code Offset and Gain Corrector

This block sits between the channel registers of a four-channel 16-bit voltage DAC and its converter core. For each request it takes a raw channel code, a signed gain trim and a signed zero trim. It returns a corrected code with three fractional bits. That result is clipped to the legal span of the channel's output mode. The four channels share one arithmetic pipeline by time multiplexing: each request carries a channel index, and that index comes back with the result two cycles later. The pipeline accepts one request every cycle.

Channels are paired into two groups, and each group has one mode input. A unipolar group reads the code as straight binary. A bipolar group reads it as two's complement. The corrected value, counted in eighths of an LSB, is the code scaled by (65536 + gain) / 65536 plus the zero trim. The scaled term is rounded to the nearest eighth. Any result that has to be clipped raises a per-result flag and a per-channel sticky flag.

Top module: `dac_trim_corrector`

## Requirements
- R1: In bipolar mode (group mode bit 0) `in_code` is two's complement (-32768..32767), and `out_code` is a 19-bit two's complement value in eighths of an LSB.
- R2: In unipolar mode (group mode bit 1) `in_code` is straight binary (0..65535), and `out_code` is a 19-bit unsigned value in eighths of an LSB.
- R3: `in_gain` is 8-bit two's complement g (-128..127). The scaled term is code × (65536 + g) / 8192 eighths, rounded to the nearest integer with exact halves going toward plus infinity. For example, code 4096 with g = +1 gives 32769, and code -4096 with g = +1 gives -32768.
- R4: With gain and zero trims both 0, `out_code` equals `in_code` followed by three zero fraction bits.
- R5: `in_zero` is 9-bit two's complement z (-256..255). It is added as z eighths after rounding; for example, +26 is encoded 0_0001_1010.
- R6: Channels 0 and 1 take their mode from `grp_unipolar[0]`, and channels 2 and 3 take it from `grp_unipolar[1]`. The mode is sampled in the same cycle as the request.
- R7: Results outside the mode's span are clipped. Unipolar results clip to 0 or 0x7FFFF. Bipolar results clip to 0x40000 (most negative) or 0x3FFFF. `out_sat` is high only together with `out_valid`, and only for a clipped result.
- R8: `ovf_sticky[c]` is set when a clipped result for channel c is presented, in the same cycle as that result. It stays set until reset.
- R9: A request accepted at a clock edge with `in_valid` high appears with `out_valid` high after exactly two edges, carrying its `in_chan` on `out_chan`. Back-to-back requests are accepted every cycle.
- R10: While in reset and after it, `out_valid`, `out_sat`, `out_code` and `ovf_sticky` read 0 until a request passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_unipolar | input | 2 | Mode per channel pair, 1 = unipolar |
| in_valid | input | 1 | Request present this cycle |
| in_chan | input | 2 | Channel index of the request |
| in_code | input | 16 | Raw channel code |
| in_gain | input | 8 | Gain trim, two's complement |
| in_zero | input | 9 | Zero trim, two's complement, eighths of an LSB |
| out_valid | output | 1 | Corrected result present |
| out_chan | output | 2 | Channel index of the result |
| out_code | output | 19 | Corrected code, 16 integer and 3 fraction bits |
| out_sat | output | 1 | This result was clipped |
| ovf_sticky | output | 4 | Per-channel record of any clipping since reset |

## Verification
The checker assumes that `in_valid` stays low while reset is applied, so the two-cycle history it compares against holds only idle values. It also assumes that the trims and mode inputs are meaningful only in a cycle where `in_valid` is high. The stimulus changes the mode pair, channel, code and trims together at the falling edge, only alongside a request, and holds `in_valid` low throughout reset. Every field is drawn from its full two's complement or binary range, so the clip boundaries and the rounding ties are reached in both modes.

// File: rtl/dac_trim_pkg.sv
package dac_trim_pkg;
  localparam int CODE_W     = 16;
  localparam int GAIN_W     = 8;
  localparam int ZERO_W     = 9;
  localparam int FRAC_W     = 3;
  localparam int N_CHAN     = 4;
  localparam int GROUP_SIZE = 2;

  localparam int CHAN_W  = $clog2(N_CHAN);
  localparam int N_GROUP = N_CHAN / GROUP_SIZE;
  localparam int XW      = CODE_W + 1;         // widened signed code
  localparam int FW      = CODE_W + 2;         // signed scale factor
  localparam int PW      = XW + FW;            // full product
  localparam int SHIFT   = CODE_W - FRAC_W;    // product to eighths
  localparam int OUT_W   = CODE_W + FRAC_W;

  typedef struct packed {
    logic [OUT_W-1:0] code;
    logic             sat;
  } clip_t;

  // Code as a signed number according to the mode.
  function automatic logic signed [XW-1:0] widen_code(
      input logic [CODE_W-1:0] c, input logic uni);
    return uni ? {1'b0, c} : {c[CODE_W-1], c};
  endfunction

  // Unity (2^CODE_W) plus the signed gain trim.
  function automatic logic signed [FW-1:0] gain_factor(
      input logic [GAIN_W-1:0] g);
    logic signed [FW-1:0] unity;
    logic signed [FW-1:0] trim;
    unity = {2'b01, {CODE_W{1'b0}}};
    trim  = {{(FW-GAIN_W){g[GAIN_W-1]}}, g};
    return unity + trim;
  endfunction

  function automatic logic signed [PW-1:0] scaled_product(
      input logic signed [XW-1:0] x, input logic signed [FW-1:0] f);
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] fe;
    xe = PW'(x);
    fe = PW'(f);
    return xe * fe;
  endfunction

  // Nearest eighth, ties toward plus infinity.
  function automatic logic signed [PW-1:0] round_eighths(
      input logic signed [PW-1:0] p);
    logic signed [PW-1:0] half;
    logic signed [PW-1:0] biased;
    half   = PW'(1) <<< (SHIFT - 1);
    biased = p + half;
    return biased >>> SHIFT;
  endfunction

  function automatic clip_t clamp_code(
      input logic signed [PW-1:0] v, input logic uni);
    logic signed [PW-1:0] one;
    logic signed [PW-1:0] lo;
    logic signed [PW-1:0] hi;
    clip_t r;
    one = PW'(1);
    if (uni) begin
      lo = '0;
      hi = (one <<< OUT_W) - one;
    end else begin
      lo = -(one <<< (OUT_W - 1));
      hi = (one <<< (OUT_W - 1)) - one;
    end
    r.sat = (v > hi) || (v < lo);
    if (v > hi)      r.code = hi[OUT_W-1:0];
    else if (v < lo) r.code = lo[OUT_W-1:0];
    else             r.code = v[OUT_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/trim_group_mode.sv
module trim_group_mode
  import dac_trim_pkg::*;
(
  input  logic [N_GROUP-1:0] grp_unipolar,
  input  logic [CHAN_W-1:0]  chan,
  output logic               uni
);
  logic [N_CHAN-1:0] chan_uni;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_map
    assign chan_uni[c] = grp_unipolar[c / GROUP_SIZE];
  end

  assign uni = chan_uni[chan];
endmodule

// File: rtl/trim_mult_stage.sv
module trim_mult_stage
  import dac_trim_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [CHAN_W-1:0]       in_chan,
  input  logic                    in_uni,
  input  logic [CODE_W-1:0]       in_code,
  input  logic [GAIN_W-1:0]       in_gain,
  input  logic [ZERO_W-1:0]       in_zero,
  output logic                    s1_valid,
  output logic [CHAN_W-1:0]       s1_chan,
  output logic                    s1_uni,
  output logic signed [ZERO_W-1:0] s1_zero,
  output logic signed [PW-1:0]    s1_prod
);
  logic signed [PW-1:0] prod_d;

  always_comb prod_d = scaled_product(widen_code(in_code, in_uni),
                                      gain_factor(in_gain));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_chan  <= '0;
      s1_uni   <= 1'b0;
      s1_zero  <= '0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_chan <= in_chan;
        s1_uni  <= in_uni;
        s1_zero <= in_zero;
        s1_prod <= prod_d;
      end
    end
  end
endmodule

// File: rtl/trim_round_sat_stage.sv
module trim_round_sat_stage
  import dac_trim_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic [CHAN_W-1:0]        s1_chan,
  input  logic                     s1_uni,
  input  logic signed [ZERO_W-1:0] s1_zero,
  input  logic signed [PW-1:0]     s1_prod,
  output logic                     sat_event,
  output logic                     out_valid,
  output logic [CHAN_W-1:0]        out_chan,
  output logic [OUT_W-1:0]         out_code,
  output logic                     out_sat,
  output logic [N_CHAN-1:0]        ovf_sticky
);
  logic signed [PW-1:0] rounded;
  logic signed [PW-1:0] biased_sum;
  clip_t                clipped;

  always_comb begin
    rounded    = round_eighths(s1_prod);
    biased_sum = rounded + PW'(s1_zero);
    clipped    = clamp_code(biased_sum, s1_uni);
  end

  assign sat_event = s1_valid && clipped.sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_code  <= '0;
      out_sat   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_sat   <= sat_event;
      if (s1_valid) begin
        out_chan <= s1_chan;
        out_code <= clipped.code;
      end
    end
  end

  for (genvar c = 0; c < N_CHAN; c++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ovf_sticky[c] <= 1'b0;
      else if (sat_event && (s1_chan == CHAN_W'(c)))
        ovf_sticky[c] <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_trim_corrector.sv
module dac_trim_corrector
  import dac_trim_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_GROUP-1:0]  grp_unipolar,
  input  logic                in_valid,
  input  logic [CHAN_W-1:0]   in_chan,
  input  logic [CODE_W-1:0]   in_code,
  input  logic [GAIN_W-1:0]   in_gain,
  input  logic [ZERO_W-1:0]   in_zero,
  output logic                out_valid,
  output logic [CHAN_W-1:0]   out_chan,
  output logic [OUT_W-1:0]    out_code,
  output logic                out_sat,
  output logic [N_CHAN-1:0]   ovf_sticky
);
  // Named internal events, observed by the bound checker.
  logic                     req_uni;
  logic                     s1_valid;
  logic [CHAN_W-1:0]        s1_chan;
  logic                     s1_uni;
  logic signed [ZERO_W-1:0] s1_zero;
  logic signed [PW-1:0]     s1_prod;
  logic                     sat_event;

  trim_group_mode u_mode (
    .grp_unipolar (grp_unipolar),
    .chan         (in_chan),
    .uni          (req_uni)
  );

  trim_mult_stage u_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_chan  (in_chan),
    .in_uni   (req_uni),
    .in_code  (in_code),
    .in_gain  (in_gain),
    .in_zero  (in_zero),
    .s1_valid (s1_valid),
    .s1_chan  (s1_chan),
    .s1_uni   (s1_uni),
    .s1_zero  (s1_zero),
    .s1_prod  (s1_prod)
  );

  trim_round_sat_stage u_sat (
    .clk        (clk),
    .rst_n      (rst_n),
    .s1_valid   (s1_valid),
    .s1_chan    (s1_chan),
    .s1_uni     (s1_uni),
    .s1_zero    (s1_zero),
    .s1_prod    (s1_prod),
    .sat_event  (sat_event),
    .out_valid  (out_valid),
    .out_chan   (out_chan),
    .out_code   (out_code),
    .out_sat    (out_sat),
    .ovf_sticky (ovf_sticky)
  );
endmodule

// File: rtl/dac_trim_corrector_chk.sv
module dac_trim_corrector_chk
  import dac_trim_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [CHAN_W-1:0]  in_chan,
  input logic [CODE_W-1:0]  in_code,
  input logic [GAIN_W-1:0]  in_gain,
  input logic [ZERO_W-1:0]  in_zero,
  input logic               out_valid,
  input logic [CHAN_W-1:0]  out_chan,
  input logic [OUT_W-1:0]   out_code,
  input logic               out_sat,
  input logic [N_CHAN-1:0]  ovf_sticky,
  input logic               s1_valid,
  input logic               s1_uni,
  input logic               sat_event
);
  localparam logic [OUT_W-1:0] UNI_HI = {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] BIP_LO = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] BIP_HI = {1'b0, {(OUT_W-1){1'b1}}};

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  assert_stage_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid == $past(in_valid));

  assert_chan_travel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 (out_chan == $past(in_chan, 2)));

  assert_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_gain == '0 && in_zero == '0) |->
      ##2 (out_code == {$past(in_code, 2), {FRAC_W{1'b0}}}));

  assert_sat_at_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat |-> ($past(s1_uni) ? (out_code == '0 || out_code == UNI_HI)
                               : (out_code == BIP_LO || out_code == BIP_HI)));

  assert_no_stray_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_sat);

  assert_sat_follows_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat == $past(sat_event));

  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (~ovf_sticky & $past(ovf_sticky)) == '0);

  assert_sticky_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sat) |-> ovf_sticky[out_chan]);
endmodule

bind dac_trim_corrector dac_trim_corrector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_chan    (in_chan),
  .in_code    (in_code),
  .in_gain    (in_gain),
  .in_zero    (in_zero),
  .out_valid  (out_valid),
  .out_chan   (out_chan),
  .out_code   (out_code),
  .out_sat    (out_sat),
  .ovf_sticky (ovf_sticky),
  .s1_valid   (s1_valid),
  .s1_uni     (s1_uni),
  .sat_event  (sat_event)
);

// File: tb/dac_trim_corrector_bench.sv
module dac_trim_corrector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  grp_unipolar = 2'b00;
  logic        in_valid = 1'b0;
  logic [1:0]  in_chan = '0;
  logic [15:0] in_code = '0;
  logic [7:0]  in_gain = '0;
  logic [8:0]  in_zero = '0;
  logic        out_valid;
  logic [1:0]  out_chan;
  logic [18:0] out_code;
  logic        out_sat;
  logic [3:0]  ovf_sticky;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  logic [3:0] exp_sticky = '0;

  typedef struct {
    int     chan;
    int     ecode;
    bit     esat;
    longint stamp;
    string  tag;
  } item_t;
  item_t sb[$];

  dac_trim_corrector u_dac_trim_corrector (
    .clk(clk), .rst_n(rst_n), .grp_unipolar(grp_unipolar),
    .in_valid(in_valid), .in_chan(in_chan), .in_code(in_code),
    .in_gain(in_gain), .in_zero(in_zero), .out_valid(out_valid),
    .out_chan(out_chan), .out_code(out_code), .out_sat(out_sat),
    .ovf_sticky(ovf_sticky)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference model written from the requirements, in plain integers.
  task automatic model(input bit uni, input int code, input int gain,
                       input int zero, output int ecode, output bit esat);
    longint x, g, z, num, r, v, lo, hi;
    x = (uni || code < 32768) ? code : code - 65536;
    g = (gain < 128) ? gain : gain - 256;
    z = (zero < 256) ? zero : zero - 512;
    num = x * (65536 + g) + 4096;
    r = (num >= 0) ? num / 8192 : -((-num + 8191) / 8192);
    v = r + z;
    lo = uni ? 0 : -262144;
    hi = uni ? 524287 : 262143;
    esat = (v < lo) || (v > hi);
    if (v < lo) v = lo;
    if (v > hi) v = hi;
    ecode = int'(v & 64'h7FFFF);
  endtask

  task automatic send(input logic [1:0] grp, input int ch, input int code,
                      input int gain, input int zero, input string tag);
    item_t it;
    @(negedge clk);
    grp_unipolar = grp;
    in_valid = 1'b1;
    in_chan  = ch[1:0];
    in_code  = code[15:0];
    in_gain  = gain[7:0];
    in_zero  = zero[8:0];
    model(grp[ch/2], code, gain, zero, it.ecode, it.esat);
    it.chan  = ch;
    it.stamp = cyc;
    it.tag   = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected out_valid", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(cyc == it.stamp + 2, "R9", "arrival cycle", cyc, it.stamp + 2);
        check(out_chan == it.chan[1:0], "R9", "out_chan", out_chan, it.chan);
        check(out_code == it.ecode[18:0], it.tag, "out_code", out_code, it.ecode);
        check(out_sat == it.esat, "R7", "out_sat", out_sat, it.esat);
        if (it.esat) exp_sticky[it.chan] = 1'b1;
        check(ovf_sticky == exp_sticky, "R8", "ovf_sticky", ovf_sticky, exp_sticky);
      end
    end else if (rst_n) begin
      check(out_sat == 1'b0, "R7", "out_sat while idle", out_sat, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual %0d expected below 200000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", "out_valid", out_valid, 0);
    check(out_code == '0, "R10", "out_code", out_code, 0);
    check(out_sat == 1'b0, "R10", "out_sat", out_sat, 0);
    check(ovf_sticky == '0, "R10", "ovf_sticky", ovf_sticky, 0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0 && ovf_sticky == '0, "R10", "after release",
          {out_valid, ovf_sticky}, 0);

    // R4 / R1 / R2: pass-through with zero trims, back to back
    send(2'b00, 0, 16'h8000, 0, 0, "R4_R1");
    send(2'b00, 1, 16'h7FFF, 0, 0, "R4_R1");
    send(2'b11, 2, 16'hFFFF, 0, 0, "R4_R2");
    send(2'b11, 3, 16'h0000, 0, 0, "R4_R2");
    send(2'b00, 3, 16'h1234, 0, 0, "R4_R1");
    idle(3);

    // R3: gain scaling and tie rounding
    send(2'b11, 0, 4096, 1, 0, "R3");          // 32768.5 -> 32769
    send(2'b00, 1, 16'hF000, 1, 0, "R3");      // -32768.5 -> -32768
    send(2'b00, 0, 4096, 8'hFF, 0, "R3");      // 32767.5 -> 32768
    send(2'b11, 2, 30000, 33, 0, "R3");
    send(2'b00, 3, 16'hC000, 8'h80, 0, "R3");
    idle(3);

    // R5: zero trim in eighths
    send(2'b11, 0, 1000, 0, 26, "R5");
    send(2'b11, 1, 1000, 0, 9'h1E6, "R5");
    send(2'b00, 3, 0, 0, 9'h100, "R5");
    send(2'b00, 2, 16'hFFFF, 33, 255, "R5");
    idle(3);

    // R6: group mode mapping, same code on both groups
    send(2'b01, 1, 16'h8000, 0, 0, "R6");
    send(2'b01, 2, 16'h8000, 0, 0, "R6");
    send(2'b10, 0, 16'h8000, 0, 0, "R6");
    send(2'b10, 3, 16'h8000, 0, 0, "R6");
    idle(3);

    // R7 / R8: clipping at every bound, first only on channel 2
    send(2'b11, 2, 16'hFFFF, 127, 0, "R7");
    idle(3);
    check(ovf_sticky == 4'b0100, "R8", "only channel 2 sticky", ovf_sticky, 4'b0100);
    send(2'b11, 1, 0, 0, 9'h1FF, "R7");
    send(2'b00, 3, 16'h7FFF, 127, 255, "R7");
    send(2'b00, 0, 16'h8000, 127, 0, "R7");
    send(2'b00, 1, 16'h8000, 0, 9'h1FF, "R7");
    send(2'b11, 0, 16'hFFFF, 0, 7, "R7");       // exactly top, no clip
    idle(4);
    check(ovf_sticky == 4'b1111, "R8", "all channels sticky", ovf_sticky, 4'b1111);

    // Mixed stream, full field ranges, random gaps
    for (int i = 0; i < 400; i++) begin
      send(2'($urandom), int'($urandom % 4), int'($urandom % 65536),
           int'($urandom % 256), int'($urandom % 512), "R3_R5_R7");
      if ($urandom % 5 == 0) idle(1);
    end
    idle(5);
    check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule